// File: doc/BRIEF.md
# Gen2 Stuck-Link Recovery Monitor

This block runs one link health check each time it is given a strobe. It looks at a readiness flag in the upper debug word, fetches the receiver-valid indication from the PHY through a request/acknowledge register port, and compares the current training-state code from the lower debug word with the receiver-lock recovery state. A link that sits in that state while the receiver reports no valid data is treated as stuck on its way to the faster rate.

For a stuck link the block performs a read-modify-write that forces two receiver override bits high. It then waits a fixed, parameterised number of clock cycles and performs a second read-modify-write that clears the same bits again. Each check ends with a one-cycle done pulse and a two-bit result: link up, not ready, recovered, or access error. A port error on any access ends the check at once. Strobes that arrive during a check are dropped.

Top module: `gen2_link_rescue`

## Requirements
- R1: Out of reset `check_done`, `link_busy` and `phy_req` are 0.
- R2: A strobe while idle with bit 4 of `dbg_hi` set gives `check_done`=1 with result 1 (not ready) in the next cycle, and no PHY access is made.
- R3: Otherwise the first access is a read (`phy_wr`=0) of address 0x100D. A request stays high with stable address, write flag and data until the cycle `phy_ack` is seen, and only one access is ever outstanding.
- R4: If bit 0 of the data returned for address 0x100D is 1, the check ends with result 0 (link up) and makes no further access.
- R5: If that bit is 0 and `dbg_lo[5:0]`, taken in the acknowledge cycle of that read, differs from 0x0D, the check ends with result 0 and makes no further access.
- R6: When the bit is 0 and the state code is 0x0D, the block reads address 0x1005 and writes back the returned value with bits 5 and 3 set (OR 0x0028).
- R7: After that write is acknowledged, `phy_req` stays low and the next request rises exactly WAIT_CYCLES+1 cycles after the acknowledge cycle.
- R8: The block then reads 0x1005 again, writes back the returned value with bits 5 and 3 cleared (AND NOT 0x0028), and ends with result 2 (recovered): five accesses in all.
- R9: An acknowledge with `phy_err` high ends the check with result 3 (access error) in the next cycle, and no further request is raised.
- R10: A strobe while `link_busy` is 1 has no effect on the accesses made or on the result.
- R11: `check_done` is a single-cycle pulse; `check_result` is valid while it is high and holds until the next check ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| check_start | input | 1 | Strobe that starts a check when idle |
| dbg_lo | input | 32 | Lower debug word; bits 5:0 carry the training-state code |
| dbg_hi | input | 32 | Upper debug word; bit 4 flags a link that is not ready |
| phy_req | output | 1 | Access request, held until acknowledged |
| phy_wr | output | 1 | 1 for a write, 0 for a read |
| phy_addr | output | 16 | PHY register address |
| phy_wdata | output | 16 | Write data |
| phy_ack | input | 1 | One-cycle access completion |
| phy_err | input | 1 | Access failed, valid with `phy_ack` |
| phy_rdata | input | 16 | Read data, valid with `phy_ack` |
| check_done | output | 1 | One-cycle pulse when the result is valid |
| check_result | output | 2 | 0 up, 1 not ready, 2 recovered, 3 access error |
| link_busy | output | 1 | A check is in progress |

## Verification
The assertions watch, on every cycle, the request handshake (hold until acknowledge, no overlapping launch), the silence of the port while the hold timer runs, the single-cycle done pulse, and the immediate outcomes of a not-ready strobe and an errored acknowledge. The decision itself (which register values are written back, whether the training-state code steers the check to the recovery path, the exact length of the hold window and the dropping of strobes during a check) only shows up in the bench's scenarios, which drive a PHY model with its own register and log every access.

// File: rtl/lr_pkg.sv
package lr_pkg;

  typedef enum logic [1:0] {
    RES_UP        = 2'd0,
    RES_NOT_READY = 2'd1,
    RES_RECOVERED = 2'd2,
    RES_PORT_ERR  = 2'd3
  } result_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RXV,
    ST_SET_RD,
    ST_SET_WR,
    ST_HOLD,
    ST_CLR_RD,
    ST_CLR_WR
  } step_e;

endpackage

// File: rtl/lr_phy_port.sv
module lr_phy_port #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic              launch_wr,
  input  logic [ADDR_W-1:0] launch_addr,
  input  logic [DATA_W-1:0] launch_data,
  input  logic              phy_ack,
  output logic              phy_req,
  output logic              phy_wr,
  output logic [ADDR_W-1:0] phy_addr,
  output logic [DATA_W-1:0] phy_wdata,
  output logic              xfer_done
);

  assign xfer_done = phy_req & phy_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      phy_req   <= 1'b0;
      phy_wr    <= 1'b0;
      phy_addr  <= '0;
      phy_wdata <= '0;
    end else if (launch) begin
      phy_req   <= 1'b1;
      phy_wr    <= launch_wr;
      phy_addr  <= launch_addr;
      phy_wdata <= launch_data;
    end else if (xfer_done) begin
      phy_req   <= 1'b0;
    end
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phy_req && !phy_ack) |=> (phy_req && $stable(phy_addr) && $stable(phy_wr) && $stable(phy_wdata)));

  // R3
  launch_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    launch |-> (!phy_req || phy_ack));

endmodule

// File: rtl/lr_hold_timer.sv
module lr_hold_timer #(
  parameter int CYCLES = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic running,
  output logic expire
);

  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)
      remain <= '0;
    else if (load)
      remain <= CW'(CYCLES);
    else if (remain != '0)
      remain <= remain - 1'b1;
  end

  assign running = (remain != '0);
  assign expire  = (remain == CW'(1));

  // R7
  timer_reload_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> !running);

endmodule

// File: rtl/gen2_link_rescue.sv
module gen2_link_rescue #(
  parameter int          WAIT_CYCLES  = 100000,
  parameter int          DBG_W        = 32,
  parameter int          ADDR_W       = 16,
  parameter int          DATA_W       = 16,
  parameter int          READY_BIT    = 4,
  parameter int          STATE_W      = 6,
  parameter logic [5:0]  STUCK_STATE  = 6'h0D,
  parameter logic [15:0] RXSTAT_ADDR  = 16'h100D,
  parameter logic [15:0] OVR_ADDR     = 16'h1005,
  parameter logic [15:0] OVR_MASK     = 16'h0028
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              check_start,
  input  logic [DBG_W-1:0]  dbg_lo,
  input  logic [DBG_W-1:0]  dbg_hi,
  output logic              phy_req,
  output logic              phy_wr,
  output logic [ADDR_W-1:0] phy_addr,
  output logic [DATA_W-1:0] phy_wdata,
  input  logic              phy_ack,
  input  logic              phy_err,
  input  logic [DATA_W-1:0] phy_rdata,
  output logic              check_done,
  output logic [1:0]        check_result,
  output logic              link_busy
);
  import lr_pkg::*;

  localparam logic [ADDR_W-1:0] RX_A   = ADDR_W'(RXSTAT_ADDR);
  localparam logic [ADDR_W-1:0] OVR_A  = ADDR_W'(OVR_ADDR);
  localparam logic [DATA_W-1:0] MASK_D = DATA_W'(OVR_MASK);

  step_e             step, step_nx;
  logic              launch, launch_wr;
  logic [ADDR_W-1:0] launch_addr;
  logic [DATA_W-1:0] launch_data;
  logic              xfer_done;
  logic              tmr_load, tmr_running, tmr_expire;
  logic              fin;
  result_e           fin_code;
  logic              rx_valid, state_stuck;

  assign rx_valid    = phy_rdata[0];
  assign state_stuck = (dbg_lo[STATE_W-1:0] == STUCK_STATE[STATE_W-1:0]);

  lr_phy_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst(rst),
    .launch(launch), .launch_wr(launch_wr),
    .launch_addr(launch_addr), .launch_data(launch_data),
    .phy_ack(phy_ack),
    .phy_req(phy_req), .phy_wr(phy_wr), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
    .xfer_done(xfer_done)
  );

  lr_hold_timer #(.CYCLES(WAIT_CYCLES)) u_hold (
    .clk(clk), .rst(rst), .load(tmr_load),
    .running(tmr_running), .expire(tmr_expire)
  );

  always_comb begin
    step_nx     = step;
    launch      = 1'b0;
    launch_wr   = 1'b0;
    launch_addr = OVR_A;
    launch_data = '0;
    tmr_load    = 1'b0;
    fin         = 1'b0;
    fin_code    = RES_UP;
    unique case (step)
      ST_IDLE: begin
        if (check_start) begin
          if (dbg_hi[READY_BIT]) begin
            fin      = 1'b1;
            fin_code = RES_NOT_READY;
          end else begin
            launch      = 1'b1;
            launch_addr = RX_A;
            step_nx     = ST_RXV;
          end
        end
      end
      ST_HOLD: begin
        if (tmr_expire) begin
          launch  = 1'b1;
          step_nx = ST_CLR_RD;
        end
      end
      default: begin
        if (xfer_done) begin
          if (phy_err) begin
            fin      = 1'b1;
            fin_code = RES_PORT_ERR;
          end else begin
            unique case (step)
              ST_RXV: begin
                if (rx_valid || !state_stuck) begin
                  fin = 1'b1;
                end else begin
                  launch  = 1'b1;
                  step_nx = ST_SET_RD;
                end
              end
              ST_SET_RD: begin
                launch      = 1'b1;
                launch_wr   = 1'b1;
                launch_data = phy_rdata | MASK_D;
                step_nx     = ST_SET_WR;
              end
              ST_SET_WR: begin
                tmr_load = 1'b1;
                step_nx  = ST_HOLD;
              end
              ST_CLR_RD: begin
                launch      = 1'b1;
                launch_wr   = 1'b1;
                launch_data = phy_rdata & ~MASK_D;
                step_nx     = ST_CLR_WR;
              end
              default: begin
                fin      = 1'b1;
                fin_code = RES_RECOVERED;
              end
            endcase
          end
        end
      end
    endcase
    if (fin) step_nx = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step         <= ST_IDLE;
      check_done   <= 1'b0;
      check_result <= RES_UP;
    end else begin
      step       <= step_nx;
      check_done <= fin;
      if (fin) check_result <= fin_code;
    end
  end

  assign link_busy = (step != ST_IDLE);

  // R2
  not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (check_start && !link_busy && dbg_hi[READY_BIT]) |=> (check_done && check_result == RES_NOT_READY && !phy_req));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    check_done |=> !check_done);

  // R7
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    tmr_running |-> !phy_req);

  // R9
  err_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (phy_req && phy_ack && phy_err) |=> (!phy_req && check_done && check_result == RES_PORT_ERR));

endmodule

// File: tb/tb_gen2_link_rescue.sv
module tb_gen2_link_rescue;

  localparam int W   = 40;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        check_start = 1'b0;
  logic [31:0] dbg_lo = '0;
  logic [31:0] dbg_hi = '0;
  logic        phy_req, phy_wr;
  logic [15:0] phy_addr, phy_wdata;
  logic        phy_ack = 1'b0;
  logic        phy_err = 1'b0;
  logic [15:0] phy_rdata = '0;
  logic        check_done;
  logic [1:0]  check_result;
  logic        link_busy;

  gen2_link_rescue #(.WAIT_CYCLES(W)) dut (
    .clk(clk), .rst(rst), .check_start(check_start),
    .dbg_lo(dbg_lo), .dbg_hi(dbg_hi),
    .phy_req(phy_req), .phy_wr(phy_wr), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
    .phy_ack(phy_ack), .phy_err(phy_err), .phy_rdata(phy_rdata),
    .check_done(check_done), .check_result(check_result), .link_busy(link_busy)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // PHY model state
  logic [15:0] ovr_reg = '0;
  logic        rxv_bit = 1'b0;
  int          err_at  = -1;
  int          n_acc   = 0;
  int          lat_cnt = 0;
  logic [15:0] log_addr [0:15];
  logic [15:0] log_data [0:15];
  logic        log_wr   [0:15];
  logic        prev_req = 1'b0;
  logic        armed    = 1'b0;
  int          wr_ack_cyc = 0;
  int          hold_gap   = -1;
  logic [1:0]  last_res;
  int          done_cnt = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    phy_ack = 1'b0;
    phy_err = 1'b0;
    if (phy_req && !prev_req && armed) begin
      hold_gap = cyc - wr_ack_cyc;
      armed = 1'b0;
    end
    prev_req = phy_req;
    if (check_done) done_cnt++;
    if (phy_req) begin
      if (lat_cnt >= LAT) begin
        lat_cnt = 0;
        phy_ack = 1'b1;
        if (n_acc < 16) begin
          log_addr[n_acc] = phy_addr;
          log_wr[n_acc]   = phy_wr;
          log_data[n_acc] = phy_wdata;
        end
        phy_err = (n_acc == err_at);
        if (phy_wr) begin
          if (phy_addr == 16'h1005 && !phy_err) ovr_reg = phy_wdata;
          if (hold_gap < 0 && !phy_err) begin
            armed = 1'b1;
            wr_ack_cyc = cyc;
          end
          phy_rdata = 16'h0000;
        end else begin
          phy_rdata = (phy_addr == 16'h100D) ? {15'h7A5C >> 0, rxv_bit} : ovr_reg;
        end
        n_acc++;
      end else begin
        lat_cnt++;
      end
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic prep(input logic [15:0] reg_init, input logic rxv, input int err_idx);
    ovr_reg  = reg_init;
    rxv_bit  = rxv;
    err_at   = err_idx;
    n_acc    = 0;
    hold_gap = -1;
    armed    = 1'b0;
    done_cnt = 0;
  endtask

  task automatic strobe();
    @(negedge clk);
    check_start = 1'b1;
    @(negedge clk);
    check_start = 1'b0;
  endtask

  task automatic wait_done(output logic [1:0] res);
    int n;
    n = 0;
    while (!check_done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    res = check_result;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check(check_done == 1'b0, "R1 done", check_done, 0);
    check(link_busy == 1'b0, "R1 busy", link_busy, 0);
    check(phy_req == 1'b0, "R1 req", phy_req, 0);
  endtask

  task automatic t_not_ready();
    prep(16'h0, 1'b0, -1);
    dbg_hi = 32'h0000_0010;
    dbg_lo = 32'h0000_000D;
    @(negedge clk);
    check_start = 1'b1;
    @(negedge clk);
    check_start = 1'b0;
    check(check_done == 1'b1, "R2 done next cycle", check_done, 1);
    check(check_result == 2'd1, "R2 result", check_result, 1);
    @(negedge clk);
    check(check_done == 1'b0, "R11 single pulse", check_done, 0);
    repeat (10) @(negedge clk);
    check(n_acc == 0, "R2 no access", n_acc, 0);
    dbg_hi = '0;
  endtask

  task automatic t_up_rxvalid();
    prep(16'h0, 1'b1, -1);
    dbg_lo = 32'hFFFF_FFCD;
    strobe();
    wait_done(last_res);
    check(last_res == 2'd0, "R4 result", last_res, 0);
    check(n_acc == 1, "R4 access count", n_acc, 1);
    check(log_addr[0] == 16'h100D && !log_wr[0], "R3 first access", log_addr[0], 16'h100D);
    check(check_result == 2'd0, "R11 result held", check_result, 0);
  endtask

  task automatic t_up_state();
    prep(16'h0, 1'b0, -1);
    dbg_lo = 32'h0000_0011;
    strobe();
    wait_done(last_res);
    check(last_res == 2'd0, "R5 result", last_res, 0);
    check(n_acc == 1, "R5 access count", n_acc, 1);
  endtask

  task automatic t_stuck(input logic [15:0] init, input logic [15:0] set_v, input logic [15:0] clr_v,
                         input logic extra_strobe);
    prep(init, 1'b0, -1);
    dbg_lo = 32'h8000_000D;
    strobe();
    if (extra_strobe) begin
      repeat (20) @(negedge clk);
      strobe();
      repeat (25) @(negedge clk);
      strobe();
    end
    wait_done(last_res);
    check(last_res == 2'd2, "R8 result", last_res, 2);
    check(n_acc == 5, "R8 access count", n_acc, 5);
    check(log_addr[1] == 16'h1005 && !log_wr[1], "R6 read", log_addr[1], 16'h1005);
    check(log_wr[2] && log_data[2] == set_v, "R6 set write", log_data[2], set_v);
    check(hold_gap == W + 1, "R7 hold window", hold_gap, W + 1);
    check(log_addr[3] == 16'h1005 && !log_wr[3], "R8 reread", log_addr[3], 16'h1005);
    check(log_wr[4] && log_data[4] == clr_v, "R8 clear write", log_data[4], clr_v);
    if (extra_strobe) begin
      check(done_cnt == 1, "R10 one completion", done_cnt, 1);
      check(link_busy == 1'b0, "R10 idle after", link_busy, 0);
    end
  endtask

  task automatic t_error(input int idx, input int exp_acc);
    prep(16'h0040, 1'b0, idx);
    dbg_lo = 32'h0000_000D;
    strobe();
    wait_done(last_res);
    repeat (W + 10) @(negedge clk);
    check(last_res == 2'd3, "R9 result", last_res, 3);
    check(n_acc == exp_acc, "R9 access stops", n_acc, exp_acc);
    check(phy_req == 1'b0, "R9 req low", phy_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_not_ready();
    t_up_rxvalid();
    t_up_state();
    t_stuck(16'h1204, 16'h122C, 16'h1204, 1'b0);
    t_stuck(16'hFFFF, 16'hFFFF, 16'hFFD7, 1'b1);
    t_error(2, 3);
    t_error(0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=0x%0h expected=0x0", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule